// File: doc/BRIEF.md
# Programmable CPU Address Window Decoder

This block decides which device a CPU physical address belongs to. Software programs a bank of twenty decode windows through a small word-wide register port. Each window holds an enable flag, a device target code, an attribute byte, a base address and a size. A purely combinational lookup path takes a 36-bit address and reports which window claimed it, the target and attribute of that window, and the address to send onward.

The first eight windows can translate. When one of them hits, the upper address bits that the window compares are replaced by a programmed remap address, and the low bits inside the window pass through. The other twelve windows send the address onward unchanged. Remappable windows have four registers each. Plain windows have two registers each and sit after a reserved gap in the register map. Software frees a window by writing zero to its registers.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every register reads zero and every lookup misses.
- R2: Control word layout: bit 0 enable, bits 7:4 target, bits 15:8 attribute, bits 31:16 size minus one in 64 KB units. Bits 3:1 read back as zero.
- R3: Base word layout: bits 31:16 hold address bits 31:16 and bits 3:0 hold address bits 35:32. Other bits read zero. A window hits when address bits 35:32 equal the stored high bits and address bits 31:16 equal the stored base bits at every position where the size field holds a 0.
- R4: A window whose enable bit is 0 never hits, whatever its other fields hold.
- R5: When several enabled windows hit, the lowest-numbered one is reported.
- R6: On a miss the miss output is 1, hit is 0, and window index, target, attribute and outgoing address are all zero. On a hit, miss is 0 and target and attribute come from the winning window.
- R7: For a hit on windows 0 to 7, outgoing bits 35:32 come from remap-high bits 3:0. Outgoing bits 31:16 come from remap-low bits 31:16 where the size field holds 0 and from the address where it holds 1. Outgoing bits 15:0 equal the address. Remap-low keeps only bits 31:16 and remap-high keeps only bits 3:0. Other bits read zero.
- R8: For a hit on windows 8 to 19, the outgoing address equals the lookup address.
- R9: Register map, byte offsets with bits 1:0 ignored. Window w below 8 sits at 16*w, with words in the order control, base, remap-low, remap-high. Window w from 8 to 19 sits at 0x90 + 8*(w-8), with control then base.
- R10: Offsets 0x80 to 0x8F and 0xF0 and above read zero. Writes to them change no register.
- R11: Writing zero to a window's control word frees it. That window stops hitting, and a lower-priority overlapping window takes over.
- R12: A register write takes effect at the clock edge that samples it. Lookups and register reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lk_addr | input | 36 | Address to decode |
| lk_hit | output | 1 | Some enabled window matched |
| lk_miss | output | 1 | No window matched |
| lk_win | output | 5 | Index of the winning window |
| lk_target | output | 4 | Target of the winning window |
| lk_attr | output | 8 | Attribute of the winning window |
| lk_out_addr | output | 36 | Outgoing, possibly remapped, address |

## Verification
A write is sampled on one rising edge and is visible from that edge on. The bench therefore drives writes on a falling edge, holds them through one rising edge, and reads or looks up only after the next falling edge. Register reads and lookups have no latency. After changing reg_addr or lk_addr, the bench waits one nanosecond inside the low half of the clock and samples the outputs there. Every comparison is against a model kept in the bench, built only from the values written and the bit layouts stated above.

// File: rtl/awd_pkg.sv
package awd_pkg;

  // Stored state of one decode window.
  typedef struct packed {
    logic        en;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [15:0] sz;       // size-1 in 64 KB units, also the pass mask
    logic [15:0] base_lo;  // address bits 31:16
    logic [3:0]  base_hi;  // address bits 35:32
  } win_cfg_t;

  // Translation state of a remappable window.
  typedef struct packed {
    logic [15:0] lo;       // outgoing bits 31:16
    logic [3:0]  hi;       // outgoing bits 35:32
  } win_rmp_t;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 36;

endpackage

// File: rtl/awd_regs.sv
module awd_regs
  import awd_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 20,
  parameter int unsigned NUM_REMAP = 8,
  parameter int unsigned PLAIN_OFF = 'h90,
  parameter int unsigned AW        = 8,
  localparam int unsigned WW       = $clog2(NUM_WIN),
  localparam int unsigned RW       = $clog2(NUM_REMAP)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr,
  input  logic [AW-1:0]                     addr,
  input  logic [REG_W-1:0]                  wdata,
  output logic [REG_W-1:0]                  rdata,
  output win_cfg_t [NUM_WIN-1:0]            cfg,
  output win_rmp_t [NUM_REMAP-1:0]          rmp
);

  localparam logic [AW-1:0] REMAP_END = AW'(NUM_REMAP * 16);
  localparam logic [AW-1:0] PLAIN_LO  = AW'(PLAIN_OFF);
  localparam logic [AW-1:0] PLAIN_END = AW'(PLAIN_OFF + (NUM_WIN - NUM_REMAP) * 8);

  logic          sel_ok;
  logic [WW-1:0] sel_win;
  logic [1:0]    sel_reg;
  logic [AW-1:0] plain_off;

  // Offset decode for the two window classes.
  always_comb begin
    sel_ok    = 1'b0;
    sel_win   = '0;
    sel_reg   = '0;
    plain_off = addr - PLAIN_LO;
    if (addr < REMAP_END) begin
      sel_ok  = 1'b1;
      sel_win = WW'(addr >> 4);
      sel_reg = addr[3:2];
    end else if (addr >= PLAIN_LO && addr < PLAIN_END) begin
      sel_ok  = 1'b1;
      sel_win = WW'(NUM_REMAP) + WW'(plain_off >> 3);
      sel_reg = {1'b0, addr[2]};
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic     hit_w;
    logic     ld_ctrl, ld_base;
    win_cfg_t cfg_nx;

    assign hit_w   = wr && sel_ok && (sel_win == WW'(w));
    assign ld_ctrl = hit_w && (sel_reg == 2'd0);
    assign ld_base = hit_w && (sel_reg == 2'd1);

    always_comb begin
      cfg_nx = cfg[w];
      if (ld_ctrl) begin
        cfg_nx.en   = wdata[0];
        cfg_nx.tgt  = wdata[7:4];
        cfg_nx.attr = wdata[15:8];
        cfg_nx.sz   = wdata[31:16];
      end
      if (ld_base) begin
        cfg_nx.base_lo = wdata[31:16];
        cfg_nx.base_hi = wdata[3:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cfg[w] <= '0;
      else if (ld_ctrl || ld_base) cfg[w] <= cfg_nx;
    end

    if (w < NUM_REMAP) begin : g_rmp
      logic     ld_rlo, ld_rhi;
      win_rmp_t rmp_nx;

      assign ld_rlo = hit_w && (sel_reg == 2'd2);
      assign ld_rhi = hit_w && (sel_reg == 2'd3);

      always_comb begin
        rmp_nx = rmp[w];
        if (ld_rlo) rmp_nx.lo = wdata[31:16];
        if (ld_rhi) rmp_nx.hi = wdata[3:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rmp[w] <= '0;
        else if (ld_rlo || ld_rhi) rmp[w] <= rmp_nx;
      end
    end
  end

  // Readback; unmapped words return zero.
  always_comb begin
    rdata = '0;
    if (sel_ok) begin
      unique case (sel_reg)
        2'd0: rdata = {cfg[sel_win].sz, cfg[sel_win].attr, cfg[sel_win].tgt,
                       3'b000, cfg[sel_win].en};
        2'd1: rdata = {cfg[sel_win].base_lo, 12'h000, cfg[sel_win].base_hi};
        2'd2: rdata = {rmp[sel_win[RW-1:0]].lo, 16'h0000};
        2'd3: rdata = {28'h0, rmp[sel_win[RW-1:0]].hi};
        default: rdata = '0;
      endcase
    end
  end

  // R10: a write outside every window leaves all state untouched.
  p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ((addr >= REMAP_END && addr < PLAIN_LO) || addr >= PLAIN_END))
    |=> ($stable(cfg) && $stable(rmp)));

  // R1: state is zero in the first cycle after reset release.
  p_reset_zero_r1: assert property (@(posedge clk)
    ($rose(rst_n) |-> (cfg == '0 && rmp == '0)));

endmodule

// File: rtl/awd_match.sv
module awd_match
  import awd_pkg::*;
#(
  parameter int unsigned NUM_WIN = 20
) (
  input  logic [ADDR_W-1:0]       lk_addr,
  input  win_cfg_t [NUM_WIN-1:0]  cfg,
  output logic [NUM_WIN-1:0]      hit_vec
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [15:0] diff;
    assign diff       = (lk_addr[31:16] ^ cfg[w].base_lo) & ~cfg[w].sz;
    assign hit_vec[w] = cfg[w].en && (diff == 16'h0) &&
                        (lk_addr[35:32] == cfg[w].base_hi);
  end

endmodule

// File: rtl/awd_pick.sv
module awd_pick
  import awd_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 20,
  parameter int unsigned NUM_REMAP = 8,
  localparam int unsigned WW       = $clog2(NUM_WIN),
  localparam int unsigned RW       = $clog2(NUM_REMAP)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         lk_addr,
  input  logic [NUM_WIN-1:0]        hit_vec,
  input  win_cfg_t [NUM_WIN-1:0]    cfg,
  input  win_rmp_t [NUM_REMAP-1:0]  rmp,
  output logic                      hit,
  output logic [WW-1:0]             win,
  output logic [3:0]                tgt,
  output logic [7:0]                attr,
  output logic [ADDR_W-1:0]         out_addr
);

  win_cfg_t    c;
  win_rmp_t    r;
  logic [15:0] mid;

  // Lowest index wins: scan from the top down.
  always_comb begin
    win = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) win = WW'(i);
    end
  end

  assign hit = |hit_vec;

  always_comb begin
    c        = cfg[win];
    r        = rmp[win[RW-1:0]];
    mid      = (r.lo & ~c.sz) | (lk_addr[31:16] & c.sz);
    tgt      = '0;
    attr     = '0;
    out_addr = '0;
    if (hit) begin
      tgt  = c.tgt;
      attr = c.attr;
      if (win < WW'(NUM_REMAP)) out_addr = {r.hi, mid, lk_addr[15:0]};
      else                      out_addr = lk_addr;
    end
  end

  // R4: a reported window is always enabled.
  p_hit_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> cfg[win].en);

  // R5: no lower window also matched.
  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((hit_vec & ((NUM_WIN'(1) << win) - NUM_WIN'(1))) == '0));

  // R8: plain windows never translate.
  p_plain_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && win >= WW'(NUM_REMAP)) |-> (out_addr == lk_addr));

  // R7: low 16 bits always survive a hit unchanged.
  p_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (out_addr[15:0] == lk_addr[15:0]));

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int unsigned NUM_WIN   = 20,
  parameter int unsigned NUM_REMAP = 8,
  parameter int unsigned PLAIN_OFF = 'h90,
  parameter int unsigned AW        = 8,
  localparam int unsigned WW       = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [35:0]        lk_addr,
  output logic               lk_hit,
  output logic               lk_miss,
  output logic [WW-1:0]      lk_win,
  output logic [3:0]         lk_target,
  output logic [7:0]         lk_attr,
  output logic [35:0]        lk_out_addr
);

  win_cfg_t [NUM_WIN-1:0]   cfg;
  win_rmp_t [NUM_REMAP-1:0] rmp;
  logic [NUM_WIN-1:0]       hit_vec;

  awd_regs #(
    .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .PLAIN_OFF(PLAIN_OFF), .AW(AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg), .rmp(rmp)
  );

  awd_match #(.NUM_WIN(NUM_WIN)) u_match (
    .lk_addr(lk_addr), .cfg(cfg), .hit_vec(hit_vec)
  );

  awd_pick #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_pick (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .hit_vec(hit_vec),
    .cfg(cfg), .rmp(rmp), .hit(lk_hit), .win(lk_win), .tgt(lk_target),
    .attr(lk_attr), .out_addr(lk_out_addr)
  );

  assign lk_miss = ~lk_hit;

  // R6: a miss leaves every result field at zero.
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (lk_out_addr == '0 && lk_win == '0 &&
                 lk_target == '0 && lk_attr == '0));

endmodule

// File: tb/addr_window_decoder_bench.sv
module addr_window_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [35:0] lk_addr = '0;
  logic        lk_hit, lk_miss;
  logic [4:0]  lk_win;
  logic [3:0]  lk_target;
  logic [7:0]  lk_attr;
  logic [35:0] lk_out_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // Bench model of readback values.
  logic [31:0] m_ctrl [20];
  logic [31:0] m_base [20];
  logic [31:0] m_rlo  [8];
  logic [31:0] m_rhi  [8];

  always #4 clk = ~clk;

  addr_window_decoder u_addr_window_decoder (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_win(lk_win),
    .lk_target(lk_target), .lk_attr(lk_attr), .lk_out_addr(lk_out_addr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] off_of(input int w, input int r);
    if (w < 8) return 8'(w * 16 + r * 4);
    return 8'('h90 + (w - 8) * 8 + r * 4);
  endfunction

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    int w, r;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    // model update from R2, R3, R7, R9
    w = -1; r = 0;
    if (a < 8'h80) begin w = a >> 4; r = (a >> 2) & 3; end
    else if (a >= 8'h90 && a < 8'hF0) begin w = 8 + ((a - 8'h90) >> 3); r = (a >> 2) & 1; end
    if (w >= 0) begin
      case (r)
        0: m_ctrl[w] = d & 32'hFFFF_FFF1;
        1: m_base[w] = d & 32'hFFFF_000F;
        2: m_rlo[w]  = d & 32'hFFFF_0000;
        default: m_rhi[w] = d & 32'h0000_000F;
      endcase
    end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic exp_lk(input logic [35:0] a, output logic h, output logic [4:0] w,
                        output logic [3:0] t, output logic [7:0] at, output logic [35:0] o);
    h = 0; w = 0; t = 0; at = 0; o = 0;
    for (int i = 0; i < 20; i++) begin
      logic [15:0] s;
      s = m_ctrl[i][31:16];
      if (!h && m_ctrl[i][0] && (a[35:32] == m_base[i][3:0]) &&
          (((a[31:16] ^ m_base[i][31:16]) & ~s) == 16'h0)) begin
        h = 1; w = 5'(i); t = m_ctrl[i][7:4]; at = m_ctrl[i][15:8];
        if (i < 8) o = {m_rhi[i][3:0], (m_rlo[i][31:16] & ~s) | (a[31:16] & s), a[15:0]};
        else       o = a;
      end
    end
  endtask

  task automatic lk_chk(input string req, input logic [35:0] a);
    logic h; logic [4:0] w; logic [3:0] t; logic [7:0] at; logic [35:0] o;
    exp_lk(a, h, w, t, at, o);
    lk_addr = a;
    #1;
    chk({req, " hit"},  64'(lk_hit), 64'(h));
    chk({req, " miss"}, 64'(lk_miss), 64'(!h));
    chk({req, " win"},  64'(lk_win), 64'(w));
    chk({req, " tgt"},  64'(lk_target), 64'(t));
    chk({req, " attr"}, 64'(lk_attr), 64'(at));
    chk({req, " addr"}, 64'(lk_out_addr), 64'(o));
  endtask

  task automatic clear_all();
    for (int w = 0; w < 20; w++) begin
      wr_reg(off_of(w, 0), 32'h0);
      wr_reg(off_of(w, 1), 32'h0);
      if (w < 8) begin
        wr_reg(off_of(w, 2), 32'h0);
        wr_reg(off_of(w, 3), 32'h0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 20; i++) begin m_ctrl[i] = 0; m_base[i] = 0; end
    for (int i = 0; i < 8; i++) begin m_rlo[i] = 0; m_rhi[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int w = 0; w < 20; w++) rd_chk("R1 reset ctrl", off_of(w, 0), 32'h0);
    rd_chk("R1 reset remap hi", off_of(7, 3), 32'h0);
    lk_chk("R1 R6 reset miss", 36'h0_0000_1234);

    // R2 R9: control layout and remappable offsets
    wr_reg(off_of(3, 0), 32'h000F_A5DF);
    rd_chk("R2 R9 ctrl readback", 8'h30, 32'h000F_A5D1);
    wr_reg(off_of(3, 1), 32'h1234_FFF5);
    rd_chk("R3 R9 base readback", 8'h34, 32'h1234_0005);
    wr_reg(off_of(3, 2), 32'hABCD_FFFF);
    rd_chk("R7 R9 remap lo readback", 8'h38, 32'hABCD_0000);
    wr_reg(off_of(3, 3), 32'hFFFF_FFF9);
    rd_chk("R7 R9 remap hi readback", 8'h3C, 32'h0000_0009);
    // R12: write visible, lookup combinational; size 0xF: bits 19:16 pass
    lk_chk("R7 R12 remap hit", 36'h5_1239_4321);
    lk_chk("R3 base hi mismatch", 36'h4_1239_4321);
    lk_chk("R3 masked bit mismatch", 36'h5_1224_0000);

    // R8 R9: plain window 10 at 0x90 + 16
    wr_reg(8'hA0, 32'h0000_3C21);
    wr_reg(8'hA4, 32'h8000_0002);
    rd_chk("R9 plain ctrl readback", 8'hA0, 32'h0000_3C21);
    rd_chk("R9 plain base readback", 8'hA4, 32'h8000_0002);
    lk_chk("R8 plain pass", 36'h2_8000_BEEF);

    // R10: hole and beyond
    wr_reg(8'h80, 32'hFFFF_FFFF);
    wr_reg(8'h8C, 32'hFFFF_FFFF);
    wr_reg(8'hF0, 32'hFFFF_FFFF);
    wr_reg(8'hFC, 32'hFFFF_FFFF);
    rd_chk("R10 hole read", 8'h84, 32'h0);
    rd_chk("R10 beyond read", 8'hF4, 32'h0);
    rd_chk("R10 neighbour remap hi", off_of(7, 3), 32'h0);
    rd_chk("R10 neighbour win8 ctrl", 8'h90, 32'h0);
    rd_chk("R10 neighbour win19 base", off_of(19, 1), 32'h0);
    lk_chk("R10 no new hit", 36'hF_FFFF_0000);

    // R5: overlapping windows 2 and 5
    wr_reg(off_of(2, 0), 32'h0003_1111);
    wr_reg(off_of(2, 1), 32'h0040_0000);
    wr_reg(off_of(5, 0), 32'h00FF_2221);
    wr_reg(off_of(5, 1), 32'h0000_0000);
    lk_chk("R5 lowest wins", 36'h0_0042_0007);
    // R11: free window 2
    wr_reg(off_of(2, 0), 32'h0);
    lk_chk("R11 freed window", 36'h0_0042_0007);
    // R4: all fields set but enable clear
    wr_reg(off_of(5, 0), 32'h00FF_22F0);
    lk_chk("R4 disabled", 36'h0_0042_0007);
    lk_chk("R6 miss", 36'h0_00F0_0000);

    // Random phase
    for (int rnd = 0; rnd < 25; rnd++) begin
      for (int w = 0; w < 20; w++) begin
        logic [15:0] sz;
        sz = ($urandom % 4 == 0) ? 16'($urandom) : 16'((1 << ($urandom % 7)) - 1);
        wr_reg(off_of(w, 0), {sz, 8'($urandom), 4'($urandom), 3'($urandom),
                              1'($urandom % 3 != 0)});
        wr_reg(off_of(w, 1), {16'($urandom) & 16'h00F3, 12'($urandom),
                              4'($urandom % 2)});
        if (w < 8) begin
          wr_reg(off_of(w, 2), $urandom);
          wr_reg(off_of(w, 3), $urandom);
        end
      end
      for (int k = 0; k < 4; k++) begin
        int w, r;
        w = $urandom % 20;
        r = (w < 8) ? $urandom % 4 : $urandom % 2;
        rd_chk("R2 R3 R7 R9 random readback", off_of(w, r),
               r == 0 ? m_ctrl[w] : r == 1 ? m_base[w] : r == 2 ? m_rlo[w] : m_rhi[w]);
      end
      for (int k = 0; k < 30; k++)
        lk_chk("R3 R4 R5 R6 R7 R8 random lookup",
               {4'($urandom % 2), 16'($urandom) & 16'h00FF, 16'($urandom)});
    end

    clear_all();
    lk_chk("R11 all cleared", 36'h0_0000_0000);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule